// File: doc/BRIEF.md
# Serial Line Bit-Period Estimator

This block watches the receive line of an asynchronous serial port and measures the widths of its pulses in clock cycles, so that host software can work out the bit period of an unknown sender and program a baud divider. It keeps the shortest low pulse and the shortest high pulse apart, and it counts the level changes seen since detection started. Once enough traffic has passed, the shorter of the two minima is a good estimate of one bit time.

Before any measurement, the raw line passes through a synchronizer and a persistence filter. A level change is accepted only once the new level has held for the programmed glitch width, so spikes disappear and merge into the level around them. Every accepted edge is delayed by the same amount, so the widths of real pulses come through unchanged. Detection runs while the enable input is high. Each rising edge of the enable restarts the measurement. While the enable is low, the results stay frozen for the host to read.

Top module: `baud_sense`

## Requirements
- R1: After reset the low-pulse and high-pulse minimum outputs are all ones (0xFFFFF at the default 20-bit width) and the edge count is 0.
- R2: A rising edge of `det_en` reloads both minima to all ones and clears the edge count. A pulse that completes in that same cycle is discarded.
- R3: A raw pulse shorter than max(`glitch_w`, 1) cycles is removed. The line is treated as staying at its surrounding level, so a rejected high spike inside a low period makes one longer low pulse. A `glitch_w` of 0 behaves like 1.
- R4: When a low pulse of W cycles (time between two accepted edges) completes, `low_min` becomes W only if W is strictly less than the stored value.
- R5: When a high pulse of W cycles completes, `high_min` becomes W only if W is strictly less than the stored value.
- R6: `edge_cnt` rises by one on each accepted edge while enabled. It stops at its maximum value (1023 by default) and does not wrap.
- R7: The level in progress when detection is enabled is not a complete pulse. Only pulses bounded by two accepted edges after enabling are measured.
- R8: While `det_en` is low, all three results hold their values regardless of line activity.
- R9: The pulse-width counter saturates at all ones. A pulse of that length or longer never lowers a minimum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| det_en | input | 1 | Detection enable; a rising edge restarts measurement |
| glitch_w | input | GW_W (8) | Minimum accepted pulse width in cycles (host default 0x10) |
| rxd_in | input | 1 | Raw asynchronous receive line, idle high |
| low_min | output | CNT_W (20) | Shortest accepted low pulse, in cycles |
| high_min | output | CNT_W (20) | Shortest accepted high pulse, in cycles |
| edge_cnt | output | EDGE_W (10) | Accepted edges since enabling, saturating |

## Verification
The bench targets pulses exactly one cycle shorter than the glitch width and exactly equal to it. A filter with an off-by-one error would either let the first kind through or drop the second, and the edge count would show the difference. It puts a rejected spike inside a long low period and expects one merged pulse, which a design that drops only the spike would report as two short pulses. It leaves the line idle for a long time around each burst, so a design that times the partial first level or the trailing idle would report a false high minimum. A narrow instance is driven with a pulse longer than its counter range, where a wrapping counter would store a small false minimum. A long toggle train checks that the edge counter stops at its maximum instead of wrapping to zero.

// File: rtl/baud_sense_pkg.sv
// Package: shared types and constants for the bit-period estimator.
// Assumes: the serial line idles high.
package baud_sense_pkg;

    // Polarity of a completed pulse on the filtered line
    typedef enum logic {
        POL_LOW  = 1'b0,
        POL_HIGH = 1'b1
    } pol_e;

    // Level of an idle line; used as reset value of line-facing state
    localparam logic IDLE_LEVEL = 1'b1;

endpackage

// File: rtl/bs_sync.sv
// Module: bs_sync
// Brings an asynchronous level into the clock domain through STAGES flops.
// Assumes: STAGES >= 1; reset value chosen by the caller.
module bs_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= RESET_VAL;
                else        chain_q <= d_async;
            end
        end else begin : g_multi
            // Shift the sample through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/bs_deglitch.sv
// Module: bs_deglitch
// Persistence filter: the clean level follows the synchronized input only
// after the input has differed from it for max(gw,1) consecutive cycles.
// Every accepted edge is delayed by the same amount, so widths are kept.
// flip is high for the one cycle in which the clean level is new.
// Assumes: line idles high after reset.
module bs_deglitch #(
    parameter int GW_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw,
    input  logic [GW_W-1:0] gw,
    output logic            level,
    output logic            flip
);
    import baud_sense_pkg::*;

    logic [GW_W-1:0] dcnt_q;
    logic [GW_W:0]   need;
    logic [GW_W:0]   next_cnt;

    // Effective threshold (0 behaves as 1) and next persistence count
    always_comb begin
        need     = (gw == '0) ? (GW_W+1)'(1) : {1'b0, gw};
        next_cnt = {1'b0, dcnt_q} + (GW_W+1)'(1);
    end

    // Track how long the input has disagreed and accept a new level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level  <= IDLE_LEVEL;
            dcnt_q <= '0;
            flip   <= 1'b0;
        end else begin
            flip <= 1'b0;
            if (raw == level) begin
                dcnt_q <= '0;
            end else if (next_cnt >= need) begin
                level  <= raw;
                dcnt_q <= '0;
                flip   <= 1'b1;
            end else begin
                dcnt_q <= next_cnt[GW_W-1:0];
            end
        end
    end

endmodule

// File: rtl/bs_pulse_timer.sv
// Module: bs_pulse_timer
// Counts cycles between accepted edges on the clean line and reports each
// completed pulse (width and polarity) for one cycle. The level in
// progress at restart is not reported. The run counter saturates.
// Assumes: flip marks the first cycle of a new clean level.
module bs_pulse_timer #(
    parameter int CNT_W = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      restart,
    input  logic                      active,
    input  logic                      flip,
    input  logic                      level,
    output logic                      done,
    output baud_sense_pkg::pol_e      done_pol,
    output logic [CNT_W-1:0]          done_width
);
    import baud_sense_pkg::*;

    localparam logic [CNT_W-1:0] RUN_MAX = '1;

    logic [CNT_W-1:0] run_q;
    logic             armed_q;

    // Run length of the current level, and whether a full pulse has begun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            armed_q <= 1'b0;
        end else if (restart) begin
            run_q   <= '0;
            armed_q <= 1'b0;
        end else if (active) begin
            if (flip) begin
                run_q   <= CNT_W'(1);
                armed_q <= 1'b1;
            end else if (run_q != RUN_MAX) begin
                run_q <= run_q + CNT_W'(1);
            end
        end
    end

    // A pulse completes when an armed timer sees an accepted edge
    always_comb begin
        done       = active && flip && armed_q && !restart;
        done_width = run_q;
        done_pol   = level ? POL_LOW : POL_HIGH;
    end

endmodule

// File: rtl/bs_min_hold.sv
// Module: bs_min_hold
// Keeps the smallest completed pulse width of one polarity. Reload sets
// the register to all ones; a sample replaces it only if strictly smaller.
// Assumes: at most one sample per cycle.
module bs_min_hold #(
    parameter int                   CNT_W = 20,
    parameter baud_sense_pkg::pol_e POL   = baud_sense_pkg::POL_LOW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reload,
    input  logic                 sample,
    input  baud_sense_pkg::pol_e sample_pol,
    input  logic [CNT_W-1:0]     width,
    output logic [CNT_W-1:0]     min_q
);

    // Reload or lower the stored minimum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q <= '1;
        end else if (reload) begin
            min_q <= '1;
        end else if (sample && (sample_pol == POL) && (width < min_q)) begin
            min_q <= width;
        end
    end

endmodule

// File: rtl/bs_edge_count.sv
// Module: bs_edge_count
// Saturating counter of accepted edges; clear has priority.
// Assumes: bump is at most one per cycle.
module bs_edge_count #(
    parameter int EDGE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              bump,
    output logic [EDGE_W-1:0] cnt_q
);

    localparam logic [EDGE_W-1:0] CNT_MAX = '1;

    // Count up to the maximum and stop there
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (clear)                      cnt_q <= '0;
        else if (bump && cnt_q != CNT_MAX)   cnt_q <= cnt_q + EDGE_W'(1);
    end

endmodule

// File: rtl/baud_sense.sv
// Module: baud_sense (top)
// Bit-period estimator: synchronizes and deglitches the receive line,
// times pulses between accepted edges, keeps low and high minima and an
// edge count. A rising edge of det_en restarts; det_en low freezes results.
// Assumes: rxd_in idles high; glitch_w is quasi-static during detection.
module baud_sense #(
    parameter int CNT_W       = 20,
    parameter int EDGE_W      = 10,
    parameter int GW_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              det_en,
    input  logic [GW_W-1:0]   glitch_w,
    input  logic              rxd_in,
    output logic [CNT_W-1:0]  low_min,
    output logic [CNT_W-1:0]  high_min,
    output logic [EDGE_W-1:0] edge_cnt
);
    import baud_sense_pkg::*;

    localparam int NUM_POL = 2;

    logic             en_q;
    logic             start;
    logic             line_sync;
    logic             line_clean;
    logic             line_flip;
    logic             pulse_done;
    pol_e             pulse_pol;
    logic [CNT_W-1:0] pulse_width;
    logic [CNT_W-1:0] mins [NUM_POL];

    // Register the enable to find its rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= det_en;
    end

    assign start = det_en && !en_q;

    bs_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (IDLE_LEVEL)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rxd_in),
        .q_sync  (line_sync)
    );

    bs_deglitch #(
        .GW_W (GW_W)
    ) u_deglitch (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (line_sync),
        .gw    (glitch_w),
        .level (line_clean),
        .flip  (line_flip)
    );

    bs_pulse_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (start),
        .active     (en_q),
        .flip       (line_flip),
        .level      (line_clean),
        .done       (pulse_done),
        .done_pol   (pulse_pol),
        .done_width (pulse_width)
    );

    generate
        for (genvar p = 0; p < NUM_POL; p++) begin : g_min
            bs_min_hold #(
                .CNT_W (CNT_W),
                .POL   (pol_e'(p))
            ) u_min (
                .clk        (clk),
                .rst_n      (rst_n),
                .reload     (start),
                .sample     (pulse_done),
                .sample_pol (pulse_pol),
                .width      (pulse_width),
                .min_q      (mins[p])
            );
        end
    endgenerate

    bs_edge_count #(
        .EDGE_W (EDGE_W)
    ) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .bump  (en_q && line_flip),
        .cnt_q (edge_cnt)
    );

    assign low_min  = mins[POL_LOW];
    assign high_min = mins[POL_HIGH];

endmodule

// File: rtl/baud_sense_chk.sv
// Module: baud_sense_chk
// Temporal checks on the estimator's results, bound into every instance.
module baud_sense_chk #(
    parameter int CNT_W  = 20,
    parameter int EDGE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              det_en,
    input logic              en_q,
    input logic              start,
    input logic [CNT_W-1:0]  low_min,
    input logic [CNT_W-1:0]  high_min,
    input logic [EDGE_W-1:0] edge_cnt
);

    AST_RELOAD_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (low_min == '1) && (high_min == '1) && (edge_cnt == '0)); // R2

    AST_LOW_MIN_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> low_min <= $past(low_min)); // R4

    AST_HIGH_MIN_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> high_min <= $past(high_min)); // R5

    AST_EDGE_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (edge_cnt == $past(edge_cnt)) ||
                   (edge_cnt == $past(edge_cnt) + EDGE_W'(1))); // R6

    AST_EDGE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && edge_cnt == '1) |=> edge_cnt == '1); // R6

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_en && !en_q) |=> $stable(low_min) && $stable(high_min) &&
                               $stable(edge_cnt)); // R8

endmodule

bind baud_sense baud_sense_chk #(
    .CNT_W  (CNT_W),
    .EDGE_W (EDGE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .det_en   (det_en),
    .en_q     (en_q),
    .start    (start),
    .low_min  (low_min),
    .high_min (high_min),
    .edge_cnt (edge_cnt)
);

// File: tb/test_baud_sense.sv
`timescale 1ns/1ps
module test_baud_sense;

    localparam int FULL = 1048575;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        det_en = 1'b0;
    logic [7:0]  glitch_w = 8'h10;
    logic        rxd_in = 1'b1;
    logic [19:0] low_min, high_min;
    logic [9:0]  edge_cnt;
    logic [7:0]  n_low, n_high;
    logic [3:0]  n_edges;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    baud_sense i_baud_sense (
        .clk(clk), .rst_n(rst_n), .det_en(det_en), .glitch_w(glitch_w),
        .rxd_in(rxd_in), .low_min(low_min), .high_min(high_min),
        .edge_cnt(edge_cnt)
    );

    baud_sense #(.CNT_W(8), .EDGE_W(4)) i_baud_sense_narrow (
        .clk(clk), .rst_n(rst_n), .det_en(det_en), .glitch_w(glitch_w),
        .rxd_in(rxd_in), .low_min(n_low), .high_min(n_high),
        .edge_cnt(n_edges)
    );

    // gw, low A, high B, low C, expected low_min, high_min, edges
    localparam int VEC [8][7] = '{
        '{ 1,  8, 12, 10,  8,   12, 4},
        '{ 4, 20,  6, 15, 15,    6, 4},
        '{16, 40, 50, 30, 30,   50, 4},
        '{16, 10, 40, 30, 30, FULL, 2},
        '{16, 30,  5, 40, 75, FULL, 2},
        '{ 0,  3,  3,  3,  3,    3, 4},
        '{ 8,  8,  8,  9,  8,    8, 4},
        '{ 8,  7, 20, 20, 20, FULL, 2}
    };

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic hold(input logic lvl, input int n);
        rxd_in = lvl;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic restart_det(input int gw);
        det_en = 1'b0;
        glitch_w = 8'(gw);
        hold(1'b1, 5);
        det_en = 1'b1;
        hold(1'b1, 30);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        hold(1'b1, 2);
        // R1: reset state
        check("R1 low_min", low_min, FULL);
        check("R1 high_min", high_min, FULL);
        check("R1 edge_cnt", edge_cnt, 0);

        // Table walk: R3 filtering, R4/R5 minima, R6 counting, R7 partial level
        for (int v = 0; v < 8; v++) begin
            restart_det(VEC[v][0]);
            hold(1'b0, VEC[v][1]);
            hold(1'b1, VEC[v][2]);
            hold(1'b0, VEC[v][3]);
            hold(1'b1, 60);
            check($sformatf("R4 R3 vec%0d low_min", v), low_min, VEC[v][4]);
            check($sformatf("R5 R7 vec%0d high_min", v), high_min, VEC[v][5]);
            check($sformatf("R6 R3 vec%0d edge_cnt", v), edge_cnt, VEC[v][6]);
        end

        // R8: freeze while disabled (results from vector 1 pattern)
        restart_det(1);
        hold(1'b0, 8); hold(1'b1, 12); hold(1'b0, 10); hold(1'b1, 60);
        det_en = 1'b0;
        hold(1'b1, 5);
        for (int k = 0; k < 5; k++) begin
            hold(1'b0, 3);
            hold(1'b1, 4);
        end
        hold(1'b1, 40);
        check("R8 low_min held", low_min, 8);
        check("R8 high_min held", high_min, 12);
        check("R8 edge_cnt held", edge_cnt, 4);

        // R2: re-enable reloads
        det_en = 1'b1;
        hold(1'b1, 10);
        check("R2 low_min reload", low_min, FULL);
        check("R2 high_min reload", high_min, FULL);
        check("R2 edge_cnt clear", edge_cnt, 0);

        // R7 and R9: long idle before, long low pulse past narrow range
        restart_det(4);
        hold(1'b1, 100);
        hold(1'b0, 300);
        hold(1'b1, 60);
        check("R4 long low_min", low_min, 300);
        check("R7 high_min untouched", high_min, FULL);
        check("R9 narrow low_min saturated", n_low, 255);
        check("R6 narrow edges", n_edges, 2);

        // R6: edge counter saturation
        restart_det(1);
        for (int k = 0; k < 1100; k++) begin
            hold(1'b0, 2);
            hold(1'b1, 2);
        end
        hold(1'b1, 20);
        check("R6 edge_cnt saturated", edge_cnt, 1023);
        check("R6 narrow edge_cnt saturated", n_edges, 15);
        check("R4 short low_min", low_min, 2);
        check("R5 short high_min", high_min, 2);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule